// File: doc/BRIEF.md
# Branch target and condition resolver

This block decides where a branch instruction sends the program counter in a core with a 20-bit address space. The decoder hands it a branch kind code, the instruction length, an 8-bit and a 16-bit displacement, an absolute address, the 4-bit code segment value, the 16-bit accumulator pair and the zero, carry and tested-bit inputs. From these it produces the next program counter, a taken indication and the number of execution clocks that the instruction costs.

Relative targets are formed from the current PC plus a fixed per-kind length plus a sign-extended displacement. Absolute targets load a 16-bit address with the upper four bits cleared or a full 20-bit address. Register-indirect targets join the segment nibble above the accumulator pair. A branch that is not taken falls through to the current PC plus the decoder's instruction length. All arithmetic wraps modulo 2^20. The results pass through an optional output register, which is present by default.

Top module: `brx_resolve`

## Requirements
- R1: Kind codes 5, 6, 7, 8 are taken when carry is 1, carry is 0, zero is 1 and zero is 0 respectively, and their target is PC + 2 + sign-extended disp8.
- R2: Kind 9 is taken when (zero OR carry) is 0, kind 10 when (zero OR carry) is 1; both target PC + 3 + sign-extended disp8.
- R3: Kinds 11, 12 and 13 are taken when the tested bit is 1; kind 11 targets PC + 3 + disp8, kinds 12 and 13 target PC + 4 + disp8 (sign-extended).
- R4: When a branch is not taken, next_pc equals cur_pc + ins_len.
- R5: Kinds 5 to 10 cost 2 clocks when not taken and 4 when taken; kinds 11 and 12 cost 3 and 5; kind 13 costs 4 and 6.
- R6: Kind 0 targets PC + 2 + sign-extended disp8 and kind 1 targets PC + 3 + sign-extended disp16; kinds 0 to 4 are always taken, cost 3 clocks, and ignore zero, carry and the tested bit.
- R7: Kind 2 loads next_pc with 0 in bits 19:16 and abs_addr[15:0] below; kind 3 loads all 20 bits of abs_addr.
- R8: Kind 4 loads next_pc with seg_hi in bits 19:16 and acc_pair in bits 15:0.
- R9: Displacements are sign-extended to 20 bits and every sum wraps modulo 2^20.
- R10: Kind codes 14 and 15 are never taken, fall through to cur_pc + ins_len and cost 2 clocks.
- R11: With the output register present, outputs reflect the inputs sampled at the previous rising clock edge, and while rst_n is low they are cleared to next_pc 0, taken 0, exec_clks 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| br_kind | input | 4 | Decoded branch kind code |
| ins_len | input | 3 | Instruction length in bytes for fall-through |
| cur_pc | input | 20 | Address of the branch instruction |
| disp8 | input | 8 | Short signed displacement |
| disp16 | input | 16 | Long signed displacement |
| abs_addr | input | 20 | Absolute target address |
| seg_hi | input | 4 | Code segment nibble for indirect targets |
| acc_pair | input | 16 | Accumulator pair for indirect targets |
| flag_z | input | 1 | Zero flag |
| flag_cy | input | 1 | Carry flag |
| test_bit | input | 1 | Value of the tested operand bit |
| next_pc | output | 20 | Resolved next program counter |
| taken | output | 1 | Branch taken indication |
| exec_clks | output | 3 | Execution clocks for this outcome |

## Verification
The condition outcome and the address wrap meet in one cycle when a branch near the top of the address space is either taken with a displacement that crosses the 2^20 boundary or falls through across it. The bench provokes this with vectors whose PC sits at 0xFFFFF or 0xFFFF0 and whose displacements are positive and negative, and judges the full 20-bit next_pc together with taken and the clock count against hand-computed values. A second overlap, reset arriving while a new branch is presented, is provoked mid-run and judged by the cleared outputs.

// File: rtl/brx_pkg.sv
package brx_pkg;

    localparam int BRX_AW    = 20;
    localparam int BRX_D8W   = 8;
    localparam int BRX_D16W  = 16;
    localparam int BRX_LENW  = 3;
    localparam int BRX_CLKW  = 3;
    localparam int BRX_KINDW = 4;

    typedef enum logic [BRX_KINDW-1:0] {
        K_JREL8    = 4'd0,
        K_JREL16   = 4'd1,
        K_JABS16   = 4'd2,
        K_JABS20   = 4'd3,
        K_JIND     = 4'd4,
        K_C_SET    = 4'd5,
        K_C_CLR    = 4'd6,
        K_Z_SET    = 4'd7,
        K_Z_CLR    = 4'd8,
        K_HI       = 4'd9,
        K_NHI      = 4'd10,
        K_BIT_NEAR = 4'd11,
        K_BIT_FAR  = 4'd12,
        K_BIT_EXT  = 4'd13
    } brk_e;

    localparam int OFS_SHORT = 2;
    localparam int OFS_MID   = 3;
    localparam int OFS_LONG  = 4;

    localparam int CLK_JUMP      = 3;
    localparam int CLK_COND_MISS = 2;
    localparam int CLK_COND_HIT  = 4;
    localparam int CLK_BIT_MISS  = 3;
    localparam int CLK_BIT_HIT   = 5;
    localparam int CLK_EXT_MISS  = 4;
    localparam int CLK_EXT_HIT   = 6;
    localparam int CLK_RESERVED  = 2;

endpackage

// File: rtl/brx_cond.sv
module brx_cond
    import brx_pkg::*;
#(
    parameter int KINDW = BRX_KINDW
) (
    input  logic [KINDW-1:0] kind,
    input  logic             flag_z,
    input  logic             flag_cy,
    input  logic             test_bit,
    output logic             take
);

    logic zc_any;

    always_comb begin
        zc_any = flag_z | flag_cy;
        unique case (kind)
            K_JREL8, K_JREL16, K_JABS16, K_JABS20, K_JIND: take = 1'b1;
            K_C_SET:                           take = flag_cy;
            K_C_CLR:                           take = ~flag_cy;
            K_Z_SET:                           take = flag_z;
            K_Z_CLR:                           take = ~flag_z;
            K_HI:                              take = ~zc_any;
            K_NHI:                             take = zc_any;
            K_BIT_NEAR, K_BIT_FAR, K_BIT_EXT:  take = test_bit;
            default:                           take = 1'b0;
        endcase
    end

endmodule

// File: rtl/brx_target.sv
module brx_target
    import brx_pkg::*;
#(
    parameter int AW    = BRX_AW,
    parameter int D8W   = BRX_D8W,
    parameter int D16W  = BRX_D16W,
    parameter int KINDW = BRX_KINDW
) (
    input  logic [KINDW-1:0] kind,
    input  logic [AW-1:0]    pc,
    input  logic [D8W-1:0]   disp8,
    input  logic [D16W-1:0]  disp16,
    input  logic [AW-1:0]    abs_addr,
    input  logic [AW-D16W-1:0] seg_hi,
    input  logic [D16W-1:0]  acc_pair,
    output logic [AW-1:0]    tgt
);

    localparam int SEGW = AW - D16W;

    logic [AW-1:0] sx8, sx16, ofs, base_sum;
    logic          use_long;

    always_comb begin
        sx8  = {{(AW-D8W){disp8[D8W-1]}}, disp8};
        sx16 = {{(AW-D16W){disp16[D16W-1]}}, disp16};

        unique case (kind)
            K_JREL8, K_C_SET, K_C_CLR, K_Z_SET, K_Z_CLR: ofs = AW'(OFS_SHORT);
            K_JREL16, K_HI, K_NHI, K_BIT_NEAR:           ofs = AW'(OFS_MID);
            K_BIT_FAR, K_BIT_EXT:                        ofs = AW'(OFS_LONG);
            default:                                     ofs = '0;
        endcase

        use_long = (kind == K_JREL16);
        base_sum = pc + ofs + (use_long ? sx16 : sx8);

        unique case (kind)
            K_JABS16: tgt = {{SEGW{1'b0}}, abs_addr[D16W-1:0]};
            K_JABS20: tgt = abs_addr;
            K_JIND:   tgt = {seg_hi, acc_pair};
            default:  tgt = base_sum;
        endcase
    end

endmodule

// File: rtl/brx_cycles.sv
module brx_cycles
    import brx_pkg::*;
#(
    parameter int KINDW = BRX_KINDW,
    parameter int CLKW  = BRX_CLKW
) (
    input  logic [KINDW-1:0] kind,
    input  logic             take,
    output logic [CLKW-1:0]  clks
);

    always_comb begin
        unique case (kind)
            K_JREL8, K_JREL16, K_JABS16, K_JABS20, K_JIND:
                clks = CLKW'(CLK_JUMP);
            K_C_SET, K_C_CLR, K_Z_SET, K_Z_CLR, K_HI, K_NHI:
                clks = take ? CLKW'(CLK_COND_HIT) : CLKW'(CLK_COND_MISS);
            K_BIT_NEAR, K_BIT_FAR:
                clks = take ? CLKW'(CLK_BIT_HIT) : CLKW'(CLK_BIT_MISS);
            K_BIT_EXT:
                clks = take ? CLKW'(CLK_EXT_HIT) : CLKW'(CLK_EXT_MISS);
            default:
                clks = CLKW'(CLK_RESERVED);
        endcase
    end

endmodule

// File: rtl/brx_resolve.sv
module brx_resolve
    import brx_pkg::*;
#(
    parameter int AW      = BRX_AW,
    parameter int D8W     = BRX_D8W,
    parameter int D16W    = BRX_D16W,
    parameter int LENW    = BRX_LENW,
    parameter int CLKW    = BRX_CLKW,
    parameter int KINDW   = BRX_KINDW,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KINDW-1:0] br_kind,
    input  logic [LENW-1:0]  ins_len,
    input  logic [AW-1:0]    cur_pc,
    input  logic [D8W-1:0]   disp8,
    input  logic [D16W-1:0]  disp16,
    input  logic [AW-1:0]    abs_addr,
    input  logic [AW-D16W-1:0] seg_hi,
    input  logic [D16W-1:0]  acc_pair,
    input  logic             flag_z,
    input  logic             flag_cy,
    input  logic             test_bit,
    output logic [AW-1:0]    next_pc,
    output logic             taken,
    output logic [CLKW-1:0]  exec_clks
);

    typedef struct packed {
        logic [AW-1:0]   pc;
        logic            tk;
        logic [CLKW-1:0] clks;
    } res_t;

    logic            take_w;
    logic [AW-1:0]   tgt_w;
    logic [CLKW-1:0] clks_w;
    logic [AW-1:0]   fall_w;
    res_t            res_d;

    brx_cond #(.KINDW(KINDW)) u_cond (
        .kind     (br_kind),
        .flag_z   (flag_z),
        .flag_cy  (flag_cy),
        .test_bit (test_bit),
        .take     (take_w)
    );

    brx_target #(.AW(AW), .D8W(D8W), .D16W(D16W), .KINDW(KINDW)) u_tgt (
        .kind     (br_kind),
        .pc       (cur_pc),
        .disp8    (disp8),
        .disp16   (disp16),
        .abs_addr (abs_addr),
        .seg_hi   (seg_hi),
        .acc_pair (acc_pair),
        .tgt      (tgt_w)
    );

    brx_cycles #(.KINDW(KINDW), .CLKW(CLKW)) u_cyc (
        .kind (br_kind),
        .take (take_w),
        .clks (clks_w)
    );

    always_comb begin
        fall_w     = cur_pc + {{(AW-LENW){1'b0}}, ins_len};
        res_d.tk   = take_w;
        res_d.pc   = take_w ? tgt_w : fall_w;
        res_d.clks = clks_w;
    end

    generate
        if (REG_OUT) begin : g_reg
            res_t res_q;
            logic live_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_q  <= '0;
                    live_q <= 1'b0;
                end else begin
                    res_q  <= res_d;
                    live_q <= 1'b1;
                end
            end

            assign next_pc   = res_q.pc;
            assign taken     = res_q.tk;
            assign exec_clks = res_q.clks;

            // R11: first cycle out of reset still shows cleared outputs
            p_reset_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
                !live_q |-> (next_pc == '0 && !taken && exec_clks == '0));

            // R1: carry-set kind follows the carry flag one cycle later
            p_carry_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (live_q && $past(br_kind) == K_C_SET) |-> (taken == $past(flag_cy)));

            // R2: higher kind taken only when both flags clear
            p_higher_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (live_q && $past(br_kind) == K_HI)
                |-> (taken == !($past(flag_z) || $past(flag_cy))));

            // R3: bit-test kinds follow the tested bit
            p_bit_test_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (live_q && ($past(br_kind) == K_BIT_NEAR || $past(br_kind) == K_BIT_FAR
                            || $past(br_kind) == K_BIT_EXT))
                |-> (taken == $past(test_bit)));

            // R4: not-taken outcome falls through by the instruction length
            p_fall_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (live_q && !taken)
                |-> (next_pc == AW'($past(cur_pc) + {{(AW-LENW){1'b0}}, $past(ins_len)})));

            // R5: clock count always within the documented span
            p_clk_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
                live_q |-> (exec_clks >= CLKW'(2) && exec_clks <= CLKW'(6)));

            // R6: unconditional kinds are taken and cost three clocks
            p_uncond_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (live_q && $past(br_kind) <= K_JIND)
                |-> (taken && exec_clks == CLKW'(CLK_JUMP)));

            // R7: short absolute form clears the top nibble
            p_abs16_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (live_q && $past(br_kind) == K_JABS16)
                |-> (next_pc[AW-1:D16W] == '0 && next_pc[D16W-1:0] == $past(abs_addr[D16W-1:0])));

            // R8: indirect target joins segment and accumulator pair
            p_indirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (live_q && $past(br_kind) == K_JIND)
                |-> (next_pc == {$past(seg_hi), $past(acc_pair)}));

            // R10: reserved kinds never branch
            p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (live_q && $past(br_kind) > K_BIT_EXT)
                |-> (!taken && exec_clks == CLKW'(CLK_RESERVED)));
        end else begin : g_comb
            assign next_pc   = res_d.pc;
            assign taken     = res_d.tk;
            assign exec_clks = res_d.clks;
        end
    endgenerate

endmodule

// File: tb/sim_brx_resolve.sv
`timescale 1ns/1ps
module sim_brx_resolve;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  br_kind = '0;
    logic [2:0]  ins_len = '0;
    logic [19:0] cur_pc = '0;
    logic [7:0]  disp8 = '0;
    logic [15:0] disp16 = '0;
    logic [19:0] abs_addr = '0;
    logic [3:0]  seg_hi = '0;
    logic [15:0] acc_pair = '0;
    logic        flag_z = 1'b0, flag_cy = 1'b0, test_bit = 1'b0;
    logic [19:0] next_pc;
    logic        taken;
    logic [2:0]  exec_clks;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    brx_resolve u0 (
        .clk(clk), .rst_n(rst_n), .br_kind(br_kind), .ins_len(ins_len),
        .cur_pc(cur_pc), .disp8(disp8), .disp16(disp16), .abs_addr(abs_addr),
        .seg_hi(seg_hi), .acc_pair(acc_pair), .flag_z(flag_z), .flag_cy(flag_cy),
        .test_bit(test_bit), .next_pc(next_pc), .taken(taken), .exec_clks(exec_clks)
    );

    typedef struct packed {
        logic [3:0]  kind;
        logic [2:0]  len;
        logic [19:0] pc;
        logic [7:0]  d8;
        logic [15:0] d16;
        logic [19:0] ab;
        logic [3:0]  seg;
        logic [15:0] acc;
        logic        z;
        logic        cy;
        logic        bt;
        logic [19:0] epc;
        logic        etk;
        logic [2:0]  eclk;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{4'd5,  3'd2, 20'h01000, 8'h10, 16'h0, 20'h0, 4'h0, 16'h0, 1'b0, 1'b1, 1'b0, 20'h01012, 1'b1, 3'd4, "R1"},
        '{4'd5,  3'd2, 20'h01000, 8'h10, 16'h0, 20'h0, 4'h0, 16'h0, 1'b0, 1'b0, 1'b0, 20'h01002, 1'b0, 3'd2, "R4"},
        '{4'd6,  3'd2, 20'h02000, 8'hF0, 16'h0, 20'h0, 4'h0, 16'h0, 1'b0, 1'b0, 1'b0, 20'h01FF2, 1'b1, 3'd4, "R1"},
        '{4'd7,  3'd2, 20'h00100, 8'h7F, 16'h0, 20'h0, 4'h0, 16'h0, 1'b1, 1'b0, 1'b0, 20'h00181, 1'b1, 3'd4, "R1"},
        '{4'd8,  3'd2, 20'h00100, 8'h7F, 16'h0, 20'h0, 4'h0, 16'h0, 1'b1, 1'b0, 1'b0, 20'h00102, 1'b0, 3'd2, "R5"},
        '{4'd9,  3'd3, 20'h03000, 8'h05, 16'h0, 20'h0, 4'h0, 16'h0, 1'b0, 1'b0, 1'b0, 20'h03008, 1'b1, 3'd4, "R2"},
        '{4'd9,  3'd3, 20'h03000, 8'h05, 16'h0, 20'h0, 4'h0, 16'h0, 1'b0, 1'b1, 1'b0, 20'h03003, 1'b0, 3'd2, "R2"},
        '{4'd10, 3'd3, 20'h03000, 8'h80, 16'h0, 20'h0, 4'h0, 16'h0, 1'b1, 1'b0, 1'b0, 20'h02F83, 1'b1, 3'd4, "R2"},
        '{4'd11, 3'd3, 20'h04000, 8'h04, 16'h0, 20'h0, 4'h0, 16'h0, 1'b0, 1'b0, 1'b1, 20'h04007, 1'b1, 3'd5, "R3"},
        '{4'd12, 3'd4, 20'h04000, 8'h04, 16'h0, 20'h0, 4'h0, 16'h0, 1'b0, 1'b0, 1'b1, 20'h04008, 1'b1, 3'd5, "R3"},
        '{4'd13, 3'd4, 20'h04000, 8'h04, 16'h0, 20'h0, 4'h0, 16'h0, 1'b0, 1'b0, 1'b0, 20'h04004, 1'b0, 3'd4, "R5"},
        '{4'd13, 3'd4, 20'h04000, 8'h04, 16'h0, 20'h0, 4'h0, 16'h0, 1'b0, 1'b0, 1'b1, 20'h04008, 1'b1, 3'd6, "R5"},
        '{4'd11, 3'd3, 20'h04000, 8'h04, 16'h0, 20'h0, 4'h0, 16'h0, 1'b1, 1'b1, 1'b0, 20'h04003, 1'b0, 3'd3, "R5"},
        '{4'd0,  3'd2, 20'hFFFFF, 8'h02, 16'h0, 20'h0, 4'h0, 16'h0, 1'b1, 1'b1, 1'b0, 20'h00003, 1'b1, 3'd3, "R9"},
        '{4'd1,  3'd3, 20'h00010, 8'h00, 16'hFFF0, 20'h0, 4'h0, 16'h0, 1'b0, 1'b0, 1'b1, 20'h00003, 1'b1, 3'd3, "R6"},
        '{4'd1,  3'd3, 20'hFFFF0, 8'h00, 16'h7FFF, 20'h0, 4'h0, 16'h0, 1'b0, 1'b1, 1'b0, 20'h07FF2, 1'b1, 3'd3, "R9"},
        '{4'd2,  3'd3, 20'h00200, 8'h00, 16'h0, 20'hABCDE, 4'h0, 16'h0, 1'b0, 1'b0, 1'b0, 20'h0BCDE, 1'b1, 3'd3, "R7"},
        '{4'd3,  3'd4, 20'h00200, 8'h00, 16'h0, 20'hABCDE, 4'h0, 16'h0, 1'b1, 1'b0, 1'b0, 20'hABCDE, 1'b1, 3'd3, "R7"},
        '{4'd4,  3'd2, 20'h00200, 8'h00, 16'h0, 20'h0, 4'h5, 16'h1234, 1'b0, 1'b1, 1'b1, 20'h51234, 1'b1, 3'd3, "R8"},
        '{4'd14, 3'd3, 20'h00500, 8'h40, 16'h0, 20'h0, 4'h0, 16'h0, 1'b1, 1'b1, 1'b1, 20'h00503, 1'b0, 3'd2, "R10"},
        '{4'd5,  3'd2, 20'hFFFFF, 8'h10, 16'h0, 20'h0, 4'h0, 16'h0, 1'b0, 1'b0, 1'b0, 20'h00001, 1'b0, 3'd2, "R9"}
    };

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        br_kind = v.kind; ins_len = v.len; cur_pc = v.pc; disp8 = v.d8;
        disp16 = v.d16; abs_addr = v.ab; seg_hi = v.seg; acc_pair = v.acc;
        flag_z = v.z; flag_cy = v.cy; test_bit = v.bt;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "reset next_pc", 32'(next_pc), 32'h0);
        chk("R11", "reset taken", 32'(taken), 32'h0);
        chk("R11", "reset clks", 32'(exec_clks), 32'h0);
        rst_n = 1'b1;
        // all-zero inputs decode as kind 0: PC 0 + 2 + 0
        @(negedge clk);
        chk("R6", "idle kind0 next_pc", 32'(next_pc), 32'h00002);

        // R11 latency: new inputs do not show before the next edge
        drive('{4'd4, 3'd2, 20'h0, 8'h0, 16'h0, 20'h0, 4'h9, 16'hBEEF, 1'b0, 1'b0, 1'b0, 20'h0, 1'b0, 3'd0, "R11"});
        #1;
        chk("R11", "held before edge", 32'(next_pc), 32'h00002);
        @(negedge clk);
        chk("R11", "after edge", 32'(next_pc), 32'h9BEEF);

        for (int i = 0; i < NV; i++) begin
            string t;
            t = $sformatf("%0s", VECS[i].tag);
            drive(VECS[i]);
            @(negedge clk);
            chk(t, $sformatf("vec%0d next_pc", i), 32'(next_pc), 32'(VECS[i].epc));
            chk(t, $sformatf("vec%0d taken", i), 32'(taken), 32'(VECS[i].etk));
            chk(t, $sformatf("vec%0d clks", i), 32'(exec_clks), 32'(VECS[i].eclk));
        end

        // R6: flags have no effect on an unconditional short branch
        drive('{4'd0, 3'd2, 20'h00040, 8'hFE, 16'h0, 20'h0, 4'h0, 16'h0, 1'b1, 1'b1, 1'b1, 20'h0, 1'b0, 3'd0, "R6"});
        @(negedge clk);
        chk("R6", "flags ignored pc", 32'(next_pc), 32'h00040);
        flag_z = 1'b0; flag_cy = 1'b0; test_bit = 1'b0;
        @(negedge clk);
        chk("R6", "flags ignored pc again", 32'(next_pc), 32'h00040);
        chk("R6", "flags ignored taken", 32'(taken), 32'h1);

        // R11: reset mid-run while a taken branch is presented
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", "mid reset next_pc", 32'(next_pc), 32'h0);
        chk("R11", "mid reset clks", 32'(exec_clks), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "resume next_pc", 32'(next_pc), 32'h00040);

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule